// File: doc/BRIEF.md
# Address Region Context Matcher

This block sits on the read-data path of a serial-flash fetch port. Each fetch address it receives is compared against four independently configured address regions, called contexts. The block then reports three things: whether a region claims the fetch, which context won, and whether the returned data must go through the counter-mode AES-128 decryptor or pass through untouched. The keystream generation is outside this block; it only produces the select that steers the data path.

Each context is described by two 32-bit descriptor words. The lower word carries the region's first 1 KB block in bits 31:10. The upper word carries the region's last 1 KB block in bits 31:10, a valid flag in bit 0 and a decrypt flag in bit 1. Decryption can be suppressed in two ways. A global enable forces every fetch to bypass when it is low. A two-bit operating mode also forces bypass when it shows a security violation or a disabled state. All outputs appear one clock after the fetch that caused them.

Top module: `ctx_region_matcher`

## Requirements
- R1: Four contexts (parameter `NUM_CTX`) are compared in parallel, each against its own pair of descriptor words, taken from slice `[32*k +: 32]` of the flattened descriptor buses for context k.
- R2: Context k matches when fetch address bits 31:10 are greater than or equal to lower-word bits 31:10 and less than or equal to upper-word bits 31:10. Both bounds are inclusive. A start above the end matches nothing.
- R3: A context whose upper-word bit 0 (valid) is 0 never matches, whatever its bounds.
- R4: When more than one context matches, `ctx_idx_o` reports the lowest-numbered matching context, and `hit_o` is 1.
- R5: A fetch that matches no context gives `hit_o` = 0, `ctx_idx_o` = 0 and `decrypt_o` = 0.
- R6: With the global enable at 1 and the operating mode at 0 (normal) or 1 (reserved), `decrypt_o` equals bit 1 of the winning context's upper word.
- R7: With the global enable at 0, `decrypt_o` is 0 for every fetch, while `hit_o` and `ctx_idx_o` still report the match.
- R8: Operating mode 2 (security violation) or 3 (logically disabled) forces `decrypt_o` to 0, while `hit_o` and `ctx_idx_o` still report the match.
- R9: `out_valid_o` is 1 exactly one cycle after a cycle with `fetch_valid_i` at 1. While `out_valid_o` is 0, `hit_o`, `ctx_idx_o` and `decrypt_o` are all 0.
- R10: A synchronous active-low reset clears `out_valid_o`, `hit_o`, `ctx_idx_o` and `decrypt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch address is valid this cycle |
| fetch_addr_i | input | 32 | Fetch byte address |
| glob_en_i | input | 1 | Global decrypt enable; 0 bypasses all fetches |
| op_mode_i | input | 2 | Operating mode: 0 normal, 1 reserved, 2 violation, 3 disabled |
| desc_lo_i | input | 128 | Lower descriptor words, context k at [32k+:32]; start block in 31:10 |
| desc_hi_i | input | 128 | Upper descriptor words; end block in 31:10, bit 1 decrypt, bit 0 valid |
| out_valid_o | output | 1 | Result valid, one cycle after the fetch |
| hit_o | output | 1 | A context claimed the fetch |
| ctx_idx_o | output | 2 | Index of the winning context |
| decrypt_o | output | 1 | 1 selects decryption, 0 selects pass-through |

## Verification
The bench builds the block with its default parameters: four contexts, a 32-bit address and a 10-bit block offset, which gives 22-bit bound fields. Random bounds and addresses are drawn from the lowest 64 blocks of the address space. This keeps regions overlapping, so priority conflicts, exact-bound hits and near misses one block outside a region occur often. Directed vectors pin the inclusive edges, an inverted region, the invalid flag, and each operating mode and global-enable combination.

// File: rtl/rm_pkg.sv
// Package rm_pkg
// Shared encodings for the region context matcher: the operating-mode
// code and the bit positions inside the upper descriptor word.
package rm_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_RSVD   = 2'd1,
        MODE_VIOL   = 2'd2,
        MODE_OFF    = 2'd3
    } op_mode_e;

    localparam int DESC_W      = 32;
    localparam int VALID_BIT   = 0;
    localparam int DECRYPT_BIT = 1;

    // True when the operating mode forbids decryption.
    function automatic logic mode_blocks(input logic [1:0] mode);
        return (mode == MODE_VIOL) || (mode == MODE_OFF);
    endfunction

endpackage

// File: rtl/rm_ctx_cmp.sv
// Module rm_ctx_cmp
// Compares one fetch address with one context's inclusive block bounds.
// Assumes the start block sits in word_lo[ADDR_W-1:GRAN_LSB] and the end
// block in word_hi[ADDR_W-1:GRAN_LSB]. Purely combinational.
module rm_ctx_cmp
    import rm_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 10
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] word_lo_i,
    input  logic [ADDR_W-1:0] word_hi_i,
    output logic              match_o,
    output logic              decrypt_req_o
);
    localparam int FIELD_W = ADDR_W - GRAN_LSB;

    logic [FIELD_W-1:0] addr_blk;
    logic [FIELD_W-1:0] start_blk;
    logic [FIELD_W-1:0] end_blk;
    logic               unused_low_bits;

    // Extract the block numbers of the address and both bounds.
    always_comb begin
        addr_blk  = addr_i[ADDR_W-1:GRAN_LSB];
        start_blk = word_lo_i[ADDR_W-1:GRAN_LSB];
        end_blk   = word_hi_i[ADDR_W-1:GRAN_LSB];
    end

    // Inclusive range test gated by the valid flag.
    always_comb begin
        match_o       = word_hi_i[VALID_BIT]
                        && (addr_blk >= start_blk)
                        && (addr_blk <= end_blk);
        decrypt_req_o = word_hi_i[DECRYPT_BIT];
    end

    assign unused_low_bits = ^{addr_i[GRAN_LSB-1:0], word_lo_i[GRAN_LSB-1:0],
                               word_hi_i[GRAN_LSB-1:DECRYPT_BIT+1]};

endmodule

// File: rtl/rm_prio_pick.sv
// Module rm_prio_pick
// Fixed-priority selector: reports whether any request is set and the
// index of the lowest-numbered set request. Index is 0 when none is set.
module rm_prio_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the top down so the lowest set index is written last.
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rm_out_stage.sv
// Module rm_out_stage
// Applies the global and mode overrides to the decrypt request and
// registers the result for a one-cycle latency. Outputs are all zero in
// any cycle that does not follow a valid fetch. Synchronous active-low reset.
module rm_out_stage
    import rm_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid_i,
    input  logic             any_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             dec_req_i,
    input  logic             glob_en_i,
    input  logic [1:0]       op_mode_i,
    output logic             out_valid_o,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             decrypt_o
);
    logic dec_next;

    // Decrypt only for a hit, a set request, global enable and a clean mode.
    always_comb begin
        dec_next = fetch_valid_i && any_i && dec_req_i && glob_en_i
                   && !mode_blocks(op_mode_i);
    end

    // Register the result; quiet outputs when no fetch was presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            hit_o       <= 1'b0;
            idx_o       <= '0;
            decrypt_o   <= 1'b0;
        end else begin
            out_valid_o <= fetch_valid_i;
            hit_o       <= fetch_valid_i && any_i;
            idx_o       <= (fetch_valid_i && any_i) ? idx_i : '0;
            decrypt_o   <= dec_next;
        end
    end

endmodule

// File: rtl/ctx_region_matcher.sv
// Module ctx_region_matcher
// Decides per fetch which of NUM_CTX address regions applies and whether
// the fetched data is to be decrypted. Descriptors are flattened buses,
// context k in slice [DESC_W*k +: DESC_W]. Results appear one cycle after
// the fetch. Assumes descriptors are stable while fetches are in flight.
module ctx_region_matcher
    import rm_pkg::*;
#(
    parameter int NUM_CTX  = 4,
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 10,
    localparam int IDX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int BUS_W   = NUM_CTX * DESC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    input  logic              glob_en_i,
    input  logic [1:0]        op_mode_i,
    input  logic [BUS_W-1:0]  desc_lo_i,
    input  logic [BUS_W-1:0]  desc_hi_i,
    output logic              out_valid_o,
    output logic              hit_o,
    output logic [IDX_W-1:0]  ctx_idx_o,
    output logic              decrypt_o
);
    logic [NUM_CTX-1:0] match_vec;
    logic [NUM_CTX-1:0] dec_vec;
    logic               any_match;
    logic [IDX_W-1:0]   win_idx;
    logic               win_dec;

    // One comparator per context.
    for (genvar k = 0; k < NUM_CTX; k++) begin : g_ctx
        rm_ctx_cmp #(
            .ADDR_W   (ADDR_W),
            .GRAN_LSB (GRAN_LSB)
        ) u_cmp (
            .addr_i        (fetch_addr_i),
            .word_lo_i     (desc_lo_i[DESC_W*k +: ADDR_W]),
            .word_hi_i     (desc_hi_i[DESC_W*k +: ADDR_W]),
            .match_o       (match_vec[k]),
            .decrypt_req_o (dec_vec[k])
        );
    end

    rm_prio_pick #(
        .N     (NUM_CTX),
        .IDX_W (IDX_W)
    ) u_pick (
        .req_i (match_vec),
        .any_o (any_match),
        .idx_o (win_idx)
    );

    // Pick the decrypt request of the winning context.
    always_comb begin
        win_dec = dec_vec[win_idx];
    end

    rm_out_stage #(
        .IDX_W (IDX_W)
    ) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_valid_i (fetch_valid_i),
        .any_i         (any_match),
        .idx_i         (win_idx),
        .dec_req_i     (win_dec),
        .glob_en_i     (glob_en_i),
        .op_mode_i     (op_mode_i),
        .out_valid_o   (out_valid_o),
        .hit_o         (hit_o),
        .idx_o         (ctx_idx_o),
        .decrypt_o     (decrypt_o)
    );

endmodule

// File: rtl/ctx_region_matcher_chk.sv
// Module ctx_region_matcher_chk
// Temporal checks on the matcher's ports, bound into every instance.
module ctx_region_matcher_chk #(
    parameter int NUM_CTX = 4,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 2,
    parameter int BUS_W   = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid_i,
    input logic [ADDR_W-1:0] fetch_addr_i,
    input logic              glob_en_i,
    input logic [1:0]        op_mode_i,
    input logic [BUS_W-1:0]  desc_lo_i,
    input logic [BUS_W-1:0]  desc_hi_i,
    input logic              out_valid_o,
    input logic              hit_o,
    input logic [IDX_W-1:0]  ctx_idx_o,
    input logic              decrypt_o
);
    logic [NUM_CTX-1:0] prev_vld;
    logic               unused_chk;

    // Remember last cycle's valid flags to judge the reported winner.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_CTX; k++) begin
            prev_vld[k] <= desc_hi_i[32*k];
        end
    end

    assign unused_chk = ^{fetch_addr_i, desc_lo_i};

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_i |=> out_valid_o);
    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid_i |=> !out_valid_o);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (!hit_o && !decrypt_o && ctx_idx_o == '0));
    assert_miss_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (!decrypt_o && ctx_idx_o == '0));
    assert_global_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && !glob_en_i) |=> !decrypt_o);
    assert_mode_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && op_mode_i[1]) |=> !decrypt_o);
    assert_winner_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && $past(rst_n)) |-> prev_vld[ctx_idx_o]);

endmodule

bind ctx_region_matcher ctx_region_matcher_chk #(
    .NUM_CTX (NUM_CTX),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .BUS_W   (BUS_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .glob_en_i     (glob_en_i),
    .op_mode_i     (op_mode_i),
    .desc_lo_i     (desc_lo_i),
    .desc_hi_i     (desc_hi_i),
    .out_valid_o   (out_valid_o),
    .hit_o         (hit_o),
    .ctx_idx_o     (ctx_idx_o),
    .decrypt_o     (decrypt_o)
);

// File: tb/sim_ctx_region_matcher.sv
// Bench for ctx_region_matcher: directed corners plus seeded random vectors.
module sim_ctx_region_matcher;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fetch_valid = 1'b0;
    logic [31:0]  fetch_addr = '0;
    logic         glob_en = 1'b0;
    logic [1:0]   op_mode = 2'd0;
    logic [31:0]  lo [4];
    logic [31:0]  hi [4];
    logic [127:0] lo_bus;
    logic [127:0] hi_bus;
    logic         out_valid;
    logic         hit;
    logic [1:0]   idx;
    logic         dec;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    // Flatten the descriptor arrays onto the buses.
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            lo_bus[32*k +: 32] = lo[k];
            hi_bus[32*k +: 32] = hi[k];
        end
    end

    ctx_region_matcher u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_valid_i (fetch_valid),
        .fetch_addr_i  (fetch_addr),
        .glob_en_i     (glob_en),
        .op_mode_i     (op_mode),
        .desc_lo_i     (lo_bus),
        .desc_hi_i     (hi_bus),
        .out_valid_o   (out_valid),
        .hit_o         (hit),
        .ctx_idx_o     (idx),
        .decrypt_o     (dec)
    );

    // Expected {out_valid, hit, idx, dec} from the requirements.
    function automatic logic [4:0] model(input logic v, input logic [31:0] a,
                                         input logic g, input logic [1:0] m);
        logic       h;
        logic [1:0] w;
        logic       d;
        h = 1'b0; w = 2'd0; d = 1'b0;
        for (int k = 3; k >= 0; k--) begin
            if (hi[k][0] && a[31:10] >= lo[k][31:10] && a[31:10] <= hi[k][31:10]) begin
                h = 1'b1; w = 2'(k);
            end
        end
        if (h) d = hi[w][1] && g && (m != 2'd2) && (m != 2'd3);
        if (!v) begin h = 1'b0; w = 2'd0; d = 1'b0; end
        return {v, h, w, d};
    endfunction

    // Apply one vector, wait for the register stage, compare.
    task automatic apply(input logic v, input logic [31:0] a, input logic g,
                         input logic [1:0] m, input string tag);
        logic [4:0] exp_v;
        logic [4:0] got;
        @(negedge clk);
        fetch_valid = v; fetch_addr = a; glob_en = g; op_mode = m;
        exp_v = model(v, a, g, m);
        @(posedge clk);
        #2;
        got = {out_valid, hit, idx, dec};
        n_vec++;
        if (got !== exp_v) begin
            n_bad++;
            $display("FAIL %s addr=%h got vld/hit/idx/dec=%b expected=%b",
                     tag, a, got, exp_v);
        end
    endtask

    task automatic set_ctx(input int k, input int s, input int e,
                           input logic vld, input logic d);
        lo[k] = {22'(s), 10'h2A5};
        hi[k] = {22'(e), 8'h00, d, vld};
    endtask

    initial begin
        int r;
        r = $urandom(32'h5EED_0042);
        for (int k = 0; k < 4; k++) set_ctx(k, 0, 0, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        n_vec++;
        if ({out_valid, hit, idx, dec} !== 5'b0) begin
            n_bad++;
            $display("FAIL R10 reset outputs got=%b expected=00000",
                     {out_valid, hit, idx, dec});
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R2: four disjoint regions, inclusive edges
        set_ctx(0, 4, 7, 1'b1, 1'b1);
        set_ctx(1, 8, 8, 1'b1, 1'b0);
        set_ctx(2, 20, 30, 1'b1, 1'b1);
        set_ctx(3, 40, 39, 1'b1, 1'b1);   // inverted: never matches
        apply(1'b1, 32'h0000_1000, 1'b1, 2'd0, "R2 start edge");
        apply(1'b1, 32'h0000_1FFF, 1'b1, 2'd0, "R2 end edge");
        apply(1'b1, 32'h0000_0FFF, 1'b1, 2'd0, "R2 below start");
        apply(1'b1, 32'h0000_2000, 1'b1, 2'd0, "R1 ctx1 single block");
        apply(1'b1, 32'h0000_2400, 1'b1, 2'd0, "R5 above end miss");
        apply(1'b1, 32'h0000_5000, 1'b1, 2'd0, "R6 ctx2 decrypt");
        apply(1'b1, 32'h0000_A000, 1'b1, 2'd0, "R2 inverted region");
        // R3: invalid context never matches
        set_ctx(2, 20, 30, 1'b0, 1'b1);
        apply(1'b1, 32'h0000_5000, 1'b1, 2'd0, "R3 invalid ctx");
        // R4: overlap, lowest index wins
        set_ctx(2, 0, 63, 1'b1, 1'b1);
        apply(1'b1, 32'h0000_2000, 1'b1, 2'd0, "R4 ctx1 over ctx2");
        apply(1'b1, 32'h0000_1800, 1'b1, 2'd0, "R4 ctx0 over ctx2");
        // R7: global off keeps hit, drops decrypt
        apply(1'b1, 32'h0000_1800, 1'b0, 2'd0, "R7 global bypass");
        // R8: modes 2 and 3 force bypass, mode 1 does not
        apply(1'b1, 32'h0000_1800, 1'b1, 2'd2, "R8 violation mode");
        apply(1'b1, 32'h0000_1800, 1'b1, 2'd3, "R8 disabled mode");
        apply(1'b1, 32'h0000_1800, 1'b1, 2'd1, "R6 reserved mode decrypts");
        // R9: no fetch gives quiet outputs
        apply(1'b0, 32'h0000_1800, 1'b1, 2'd0, "R9 idle");
        apply(1'b1, 32'hFFFF_FC00, 1'b1, 2'd0, "R5 top of space miss");

        // Random: bounds and addresses in the low 64 blocks
        for (int i = 0; i < 3000; i++) begin
            if (i % 16 == 0) begin
                for (int k = 0; k < 4; k++) begin
                    int s;
                    s = int'($urandom_range(0, 63));
                    set_ctx(k, s, s + int'($urandom_range(0, 12)) - 2,
                            ($urandom_range(0, 7) != 0), 1'($urandom));
                end
            end
            apply(($urandom_range(0, 9) != 0),
                  {16'h0, 6'($urandom), 10'($urandom)},
                  ($urandom_range(0, 7) != 0),
                  ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'd0,
                  "R2/R4/R6 random");
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired got=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule